// File: doc/BRIEF.md
# Shared Single-Port Data Memory with Tagged Response Broadcast

This block lets several processor cores share one data memory that has a single access port. Each core presents a request channel with a valid flag, a load/store select, a word address and store data. Each cycle the block picks at most one requester. The lowest-numbered requesting core wins. The block then performs that access on the memory array. A losing core sees its ready line low and keeps its request up until it is granted.

A store needs no answer, so the core is free again as soon as its ready line is high. A load result goes out one cycle after the grant on a single response bus. Every core sees that bus. The result carries a tag holding the index of the owning core. Each core has its own accept line, which is high only when the bus holds a valid result carrying that core's tag. Nothing takes the result off the bus: it stays for one full cycle and the next cycle's result replaces it. One core therefore cannot block the response path for the others.

Both the request side and the response side pass straight through within the cycle. A granted access costs only the single register stage of the memory read. The number of cores is a parameter. The priority logic grows with the request vector and needs no other change.

Top module: `shared_mem_arbiter`

## Requirements
- R1: In any cycle at most one core's `req_ready` bit is high, so the memory performs at most one access.
- R2: When several cores request in the same cycle, `req_ready` is high for the lowest-index requester and low for every other core.
- R3: In the cycle after a granted store, or after a cycle with no grant, `rsp_valid` is low. A store produces no response.
- R4: A load granted in cycle t puts `rsp_valid`=1 and `rsp_tag` equal to the granted core's index on the bus in cycle t+1.
- R5: The `rsp_data` of a load equals the last word stored at that address. This includes a store granted in the cycle right before the load.
- R6: `rsp_accept[i]` is 1 exactly when `rsp_valid` is 1 and `rsp_tag` equals i. So exactly one accept bit is high while a response is valid, and none is high otherwise.
- R7: Loads granted in consecutive cycles give responses in consecutive cycles, with no bubble. Each response is visible for exactly one cycle, whichever cores observe it.
- R8: Synchronous active-low reset clears `rsp_valid`. It leaves the memory contents unchanged, so a load after reset returns data stored before reset.
- R9: A core whose `req_valid` bit is low never has its `req_ready` bit high.
- R10: Addresses 0 and DEPTH-1 (word addressing, DEPTH = 2**ADDR_W) are stored and loaded like any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | NUM_CORES | Per-core request present |
| req_store | input | NUM_CORES | Per-core access kind: 1 = store, 0 = load |
| req_addr | input | NUM_CORES*ADDR_W | Per-core word address; core i uses bits [i*ADDR_W +: ADDR_W] |
| req_wdata | input | NUM_CORES*DATA_W | Per-core store data; core i uses bits [i*DATA_W +: DATA_W] |
| req_ready | output | NUM_CORES | Per-core grant; the request is taken in this cycle |
| rsp_valid | output | 1 | A load result is on the response bus |
| rsp_tag | output | TAG_W | Index of the core that owns the result |
| rsp_data | output | DATA_W | Loaded word |
| rsp_accept | output | NUM_CORES | Per-core match of the response tag |

## Verification
The assertions assume three things about the inputs. A core keeps its request up until it sees ready. Requests are idle while reset is low. No load reads a word that has never been written since power-up.

The stimulus meets all three. A pending mask holds each contending core's request until the bench's own lowest-index choice grants it. Every cycle of reset is driven idle. Every address is stored before it is loaded.

A scoreboard queue receives one expected item per cycle: either a tagged load result or no response. It compares that item with the bus one cycle after the grant.

// File: rtl/smarb_pkg.sv
// Package: shared types and helpers for the shared memory arbiter.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package smarb_pkg;

    // Kind of access carried by a request channel.
    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_kind_e;

    // Tag width for a given core count; at least one bit.
    function automatic int tag_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/smarb_prio_grant.sv
// Module: fixed-priority grant. Core 0 has the highest priority.
// Produces a one-hot grant vector plus the binary index of the winner.
// Assumes: requesters hold their request until granted (not required for
// correctness of this module, only for fairness of the whole block).
module smarb_prio_grant #(
    parameter int NUM_CORES = 4,
    parameter int TAG_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] req,
    output logic [NUM_CORES-1:0] grant,
    output logic [TAG_W-1:0]     grant_idx,
    output logic                 grant_any
);

    // Walk from the highest index down so the lowest requester wins last.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                grant_idx = TAG_W'(i);
                grant_any = 1'b1;
            end
        end
    end

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R1

    AST_NO_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0); // R9

    generate
        for (genvar g = 1; g < NUM_CORES; g++) begin : g_prio_chk
            AST_LOWER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                grant[g] |-> (req[g-1:0] == '0)); // R2
        end
    endgenerate

endmodule

// File: rtl/smarb_mem_array.sv
// Module: single-port word memory. One access per cycle: a write stores
// wr_data; a read registers the addressed word onto rd_data for the next cycle.
// Assumes: wr_en and rd_en are never both high. The contents have no reset.
module smarb_mem_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Perform the single granted access on the array.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wr_data;
        end else if (rd_en) begin
            rd_data <= mem[addr];
        end
    end

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en)); // R1

endmodule

// File: rtl/smarb_rsp_stage.sv
// Module: response broadcast register. Captures the owner tag of a granted
// load and raises valid for exactly the following cycle. Nothing dequeues it.
// Assumes: load_go is high only for a granted load.
module smarb_rsp_stage #(
    parameter int NUM_CORES = 4,
    parameter int TAG_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_go,
    input  logic [TAG_W-1:0]     load_idx,
    output logic                 rsp_valid,
    output logic [TAG_W-1:0]     rsp_tag,
    output logic [NUM_CORES-1:0] rsp_accept
);

    // Retire the old response and prepare the new one every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_tag   <= '0;
        end else begin
            rsp_valid <= load_go;
            if (load_go) begin
                rsp_tag <= load_idx;
            end
        end
    end

    // Each core compares the broadcast tag against its own index.
    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_accept
            assign rsp_accept[c] = rsp_valid && (rsp_tag == TAG_W'(c));
        end
    endgenerate

    AST_LOAD_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> (rsp_valid && rsp_tag == $past(load_idx))); // R4

    AST_QUIET_AFTER_NONLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_go |=> !rsp_valid); // R3

    AST_ACCEPT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot(rsp_accept)); // R6

    AST_ACCEPT_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_accept == '0)); // R6

endmodule

// File: rtl/shared_mem_arbiter.sv
// Module: top of the shared single-port data memory. Picks one core per cycle
// by fixed priority, performs its access, and broadcasts load results with an
// owner tag one cycle after the grant.
// Assumes: requests are idle during reset; cores hold requests until ready.
module shared_mem_arbiter #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int TAG_W     = smarb_pkg::tag_width(NUM_CORES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          req_valid,
    input  logic [NUM_CORES-1:0]          req_store,
    input  logic [NUM_CORES*ADDR_W-1:0]   req_addr,
    input  logic [NUM_CORES*DATA_W-1:0]   req_wdata,
    output logic [NUM_CORES-1:0]          req_ready,
    output logic                          rsp_valid,
    output logic [TAG_W-1:0]              rsp_tag,
    output logic [DATA_W-1:0]             rsp_data,
    output logic [NUM_CORES-1:0]          rsp_accept
);
    import smarb_pkg::*;

    logic [TAG_W-1:0]  win_idx;
    logic              win_any;
    acc_kind_e         win_kind;
    logic [ADDR_W-1:0] win_addr;
    logic [DATA_W-1:0] win_data;
    logic              do_store;
    logic              do_load;

    smarb_prio_grant #(
        .NUM_CORES (NUM_CORES),
        .TAG_W     (TAG_W)
    ) u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_valid),
        .grant     (req_ready),
        .grant_idx (win_idx),
        .grant_any (win_any)
    );

    // Steer the winning core's channel onto the single memory port.
    always_comb begin
        win_kind = ACC_LOAD;
        win_addr = '0;
        win_data = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (req_ready[i]) begin
                win_kind = acc_kind_e'(req_store[i]);
                win_addr = req_addr[i*ADDR_W +: ADDR_W];
                win_data = req_wdata[i*DATA_W +: DATA_W];
            end
        end
    end

    assign do_store = win_any && (win_kind == ACC_STORE);
    assign do_load  = win_any && (win_kind == ACC_LOAD);

    smarb_mem_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_store),
        .rd_en   (do_load),
        .addr    (win_addr),
        .wr_data (win_data),
        .rd_data (rsp_data)
    );

    smarb_rsp_stage #(
        .NUM_CORES (NUM_CORES),
        .TAG_W     (TAG_W)
    ) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_go    (do_load),
        .load_idx   (win_idx),
        .rsp_valid  (rsp_valid),
        .rsp_tag    (rsp_tag),
        .rsp_accept (rsp_accept)
    );

    AST_READY_ONLY_IF_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0); // R9

endmodule

// File: tb/test_shared_mem_arbiter.sv
// Bench: scoreboard. The driver pushes one expected bus item per cycle;
// the monitor pops and compares it one cycle later.
module test_shared_mem_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int TW = 2;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req_valid = '0;
    logic [N-1:0]      req_store = '0;
    logic [N*AW-1:0]   req_addr = '0;
    logic [N*DW-1:0]   req_wdata = '0;
    logic [N-1:0]      req_ready;
    logic              rsp_valid;
    logic [TW-1:0]     rsp_tag;
    logic [DW-1:0]     rsp_data;
    logic [N-1:0]      rsp_accept;

    typedef struct packed {
        logic          vld;
        logic [TW-1:0] tag;
        logic [DW-1:0] data;
    } exp_t;

    exp_t        sb_q[$];
    logic [DW-1:0] model [DEPTH];
    logic [AW-1:0] c_addr [N];
    logic [DW-1:0] c_data [N];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_mem_arbiter #(.NUM_CORES(N), .ADDR_W(AW), .DATA_W(DW)) i_shared_mem_arbiter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .rsp_accept(rsp_accept)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare the bus with the item expected for this cycle.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check("R3/R4 rsp_valid", 64'(rsp_valid), 64'(e.vld));
            if (e.vld) begin
                check("R4 rsp_tag", 64'(rsp_tag), 64'(e.tag));
                check("R5 rsp_data", 64'(rsp_data), 64'(e.data));
                check("R6 rsp_accept", 64'(rsp_accept), 64'(1 << e.tag));
            end else begin
                check("R6 rsp_accept idle", 64'(rsp_accept), 64'(0));
            end
        end
    end

    // Driver: apply one cycle of requests, check ready, push the expected item.
    task automatic drive(input logic [N-1:0] v, input logic [N-1:0] st);
        logic [N-1:0] exp_rdy;
        exp_t e;
        @(negedge clk);
        #1;
        req_valid = v;
        req_store = st;
        for (int i = 0; i < N; i++) begin
            req_addr[i*AW +: AW]  = c_addr[i];
            req_wdata[i*DW +: DW] = c_data[i];
        end
        #1;
        exp_rdy = '0;
        e = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (v[i]) exp_rdy = N'(1 << i);
        end
        check("R1/R2/R9 req_ready", 64'(req_ready), 64'(exp_rdy));
        for (int i = 0; i < N; i++) begin
            if (exp_rdy[i]) begin
                if (st[i]) begin
                    model[c_addr[i]] = c_data[i];
                end else begin
                    e.vld  = 1'b1;
                    e.tag  = TW'(i);
                    e.data = model[c_addr[i]];
                end
            end
        end
        sb_q.push_back(e);
    endtask

    // Contention: requests stay up until granted, lowest index first.
    task automatic contend(input logic [N-1:0] m, input logic [N-1:0] st);
        logic [N-1:0] pend;
        pend = m;
        while (pend != '0) begin
            drive(pend, st);
            for (int i = 0; i < N; i++) begin
                if (pend[i]) begin
                    pend[i] = 1'b0;
                    break;
                end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive('0, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            c_addr[i] = '0;
            c_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R8 rsp_valid in reset", 64'(rsp_valid), 64'(0));
        check("R6 accept in reset", 64'(rsp_accept), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // R3: single stores from each core, one at a time.
        for (int i = 0; i < N; i++) begin
            c_addr[i] = AW'(8 + i);
            c_data[i] = 32'hA000_0000 + 32'(i);
            drive(N'(1 << i), N'(1 << i));
        end
        // R4/R5: each core loads its own word.
        for (int i = 0; i < N; i++) drive(N'(1 << i), '0);
        idle(1);

        // R2/R7: all cores load at once; grants in index order, back-to-back.
        contend('1, '0);
        idle(1);

        // R2: all cores store at once to a fresh address each, then read back.
        for (int i = 0; i < N; i++) begin
            c_addr[i] = AW'(20 + i);
            c_data[i] = 32'h5A5A_0000 + 32'(i * 17);
        end
        contend('1, '1);
        contend(4'b1010, '0);
        contend(4'b0101, '0);

        // R5: store by core 2 then load of same address by core 1 next cycle.
        c_addr[2] = AW'(30); c_data[2] = 32'hDEAD_BEEF;
        c_addr[1] = AW'(30);
        drive(4'b0100, 4'b0100);
        drive(4'b0010, '0);
        // Mixed: core 0 stores while core 3 waits to load same address.
        c_addr[0] = AW'(30); c_data[0] = 32'h1234_5678;
        c_addr[3] = AW'(30);
        contend(4'b1001, 4'b0001);
        idle(1);

        // R10: address boundaries.
        c_addr[3] = AW'(0);         c_data[3] = 32'hFFFF_0000;
        c_addr[1] = AW'(DEPTH - 1); c_data[1] = 32'h0000_FFFF;
        drive(4'b1000, 4'b1000);
        drive(4'b0010, 4'b0010);
        drive(4'b1000, '0);
        drive(4'b0010, '0);
        idle(2);

        // R8: reset keeps memory, clears valid.
        c_addr[2] = AW'(40); c_data[2] = 32'hCAFE_0042;
        drive(4'b0100, 4'b0100);
        drive(4'b0100, '0);
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        req_valid = '0;
        sb_q.delete();
        repeat (2) @(negedge clk);
        check("R8 rsp_valid after reset", 64'(rsp_valid), 64'(0));
        #1;
        rst_n = 1'b1;
        drive(4'b0100, '0);
        drive(4'b0001, '0);
        idle(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule